// File: doc/BRIEF.md
# Filtered PLL Lock Detector

This block decides whether a phase-locked loop can be called locked. It watches the output pulses of the reference divider and of the feedback divider, and it times the gap between their rising edges with a fast sampling clock. A gap is one completed pair of edges. Most gaps are discarded: the block judges only the last gap of each group of `DECIM` completed pairs. It raises its lock indicator only after a run of `GOOD_RUN` judged gaps that are all tight. It drops the indicator on the first judged gap that is clearly too wide.

Two thresholds, given in sampling-clock ticks, form a hysteresis band. A gap below `LOCK_WIN` counts toward lock. A gap above `UNLOCK_WIN` breaks lock. A gap between the two breaks the run of good gaps but leaves the current lock state alone. If one divider edge arrives and its partner does not follow within `TIMEOUT` ticks, the pair is closed and treated as a very large error.

The indicator is forced low when lock reporting is disabled. It is also forced low while the synthesizer is powered down, and power-down clears all internal state. Both divider pulses are assumed to be synchronous to the sampling clock.

Top module: `pll_lock_filter`

## Requirements
- R1: The phase error of a pair is the number of sampling-clock cycles from the rising edge of one divider pulse to the rising edge of the other, in either order. Edges in the same cycle give an error of 0.
- R2: Only the `DECIM`-th completed pair (default 64) of each group is compared, and the other pairs in the group have no effect on the indicator.
- R3: `lockOut` rises after `GOOD_RUN` (default 4) consecutive compared pairs have an error below `LOCK_WIN` (default 2).
- R4: A compared pair with an error at or above `LOCK_WIN` restarts the consecutive-good count from zero.
- R5: A compared pair with an error above `UNLOCK_WIN` (default 2) clears lock at once.
- R6: A compared error of at least `LOCK_WIN` and at most `UNLOCK_WIN` leaves the lock state unchanged.
- R7: When one edge has no partner edge within `TIMEOUT` cycles (default 20), the pair closes and counts as an error above both windows.
- R8: While `ldEnable` is 0, `lockOut` is 0. The internal lock state is kept, so `lockOut` shows it again once `ldEnable` returns to 1.
- R9: While `powerDown` is 1, `lockOut` is 0, and the lock state, the good-run count and the pair count are all cleared.
- R10: `lockOut` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock that times the divider edges |
| rstN | input | 1 | Active-low synchronous reset |
| powerDown | input | 1 | Synthesizer powered down; clears the detector state |
| ldEnable | input | 1 | Lock reporting enable; 0 forces the indicator low |
| refPulse | input | 1 | Reference divider output pulse |
| fbPulse | input | 1 | Feedback divider output pulse |
| lockOut | output | 1 | Filtered lock indicator |

## Verification
A pair counter that drifts out of step moves the compare onto a filler pair. The stimulus uses wide filler gaps and a chosen final gap, so this drift shows up within one group of 64 pairs as a wrong `lockOut`. An off-by-one in the good-run counter or in either window comparison changes the block in which `lockOut` rises or falls. That block is visible at the end of the group it affects. Stale state left after power-down shows as lock returning one or more groups too early.

// File: rtl/ld_pkg.sv
package ld_pkg;
  // Strobes from the phase timing path to the lock control.
  typedef struct packed {
    logic cmp;   // a decimated compare happens this cycle
    logic good;  // error below the lock window
    logic bad;   // error above the unlock window, or a timeout
  } ld_strobe_t;
endpackage

// File: rtl/ld_phase_path.sv
module ld_phase_path
  import ld_pkg::*;
#(
  parameter int TIMEOUT    = 20,
  parameter int LOCK_WIN   = 2,
  parameter int UNLOCK_WIN = 2,
  parameter int DECIM      = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerDown,
  input  logic       refPulse,
  input  logic       fbPulse,
  output ld_strobe_t strobe
);
  localparam int TMR_W = $clog2(TIMEOUT + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT);
  localparam int DEC_W = $clog2(DECIM);
  localparam logic [DEC_W-1:0] DEC_LAST = DEC_W'(DECIM - 1);

  logic refQ, fbQ, pending, leadRef;
  logic [TMR_W-1:0] timer;
  logic [DEC_W-1:0] decCnt;
  logic refEdge, fbEdge, partnerEdge;
  logic pairDone, pairLate;
  logic [TMR_W-1:0] pairErr;

  assign refEdge     = refPulse & ~refQ;
  assign fbEdge      = fbPulse & ~fbQ;
  assign partnerEdge = leadRef ? fbEdge : refEdge;

  // Close a pair on the partner edge, on a timeout, or on coincident edges.
  always_comb begin
    pairDone = 1'b0;
    pairLate = 1'b0;
    pairErr  = '0;
    if (pending) begin
      if (partnerEdge) begin
        pairDone = 1'b1;
        pairErr  = timer;
      end else if (timer == TMR_LAST) begin
        pairDone = 1'b1;
        pairLate = 1'b1;
        pairErr  = timer;
      end
    end else if (refEdge && fbEdge) begin
      pairDone = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || powerDown) begin
      refQ    <= 1'b0;
      fbQ     <= 1'b0;
      pending <= 1'b0;
      leadRef <= 1'b0;
      timer   <= '0;
      decCnt  <= '0;
      strobe  <= '0;
    end else begin
      refQ <= refPulse;
      fbQ  <= fbPulse;
      if (pending) begin
        if (pairDone) pending <= 1'b0;
        else          timer   <= timer + 1'b1;
      end else if (refEdge ^ fbEdge) begin
        pending <= 1'b1;
        leadRef <= refEdge;
        timer   <= TMR_W'(1);
      end
      if (pairDone) decCnt <= (decCnt == DEC_LAST) ? '0 : decCnt + 1'b1;
      strobe.cmp  <= pairDone && (decCnt == DEC_LAST);
      strobe.good <= !pairLate && (int'(pairErr) < LOCK_WIN);
      strobe.bad  <= pairLate || (int'(pairErr) > UNLOCK_WIN);
    end
  end

  // The pair timer never runs past the timeout.
  assert_timer_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TMR_LAST);

  // A measured error never exceeds the timeout.
  assert_err_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    pairDone |-> (pairErr <= TMR_LAST));

  // A compare strobe only follows a pair that has just closed.
  assert_cmp_after_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmp |-> $past(pairDone));
endmodule

// File: rtl/ld_lock_ctrl.sv
module ld_lock_ctrl
  import ld_pkg::*;
#(
  parameter int GOOD_RUN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerDown,
  input  logic       ldEnable,
  input  ld_strobe_t strobe,
  output logic       lockOut
);
  localparam int RUN_W = $clog2(GOOD_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(GOOD_RUN);

  logic [RUN_W-1:0] runCnt;
  logic locked;

  always_ff @(posedge clk) begin
    if (!rstN || powerDown) begin
      runCnt <= '0;
      locked <= 1'b0;
    end else if (strobe.cmp) begin
      if (strobe.good) begin
        if (runCnt != RUN_MAX) runCnt <= runCnt + 1'b1;
        if (runCnt >= RUN_MAX - 1'b1) locked <= 1'b1;
      end else begin
        runCnt <= '0;
        if (strobe.bad) locked <= 1'b0;
      end
    end
  end

  assign lockOut = locked & ldEnable & ~powerDown;

  // Lock only rises right after a good compare.
  assert_rise_on_good_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(strobe.cmp && strobe.good));

  // A non-good compare restarts the run.
  assert_run_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmp && !strobe.good && !powerDown) |=> (runCnt == '0));

  // A bad compare drops lock on the next cycle.
  assert_bad_unlocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmp && strobe.bad) |=> !locked);

  // Power-down clears the run and the lock state.
  assert_powerdown_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (!locked && runCnt == '0));
endmodule

// File: rtl/pll_lock_filter.sv
module pll_lock_filter
  import ld_pkg::*;
#(
  parameter int TIMEOUT    = 20,
  parameter int LOCK_WIN   = 2,
  parameter int UNLOCK_WIN = 2,
  parameter int DECIM      = 64,
  parameter int GOOD_RUN   = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic powerDown,
  input  logic ldEnable,
  input  logic refPulse,
  input  logic fbPulse,
  output logic lockOut
);
  ld_strobe_t strobe;

  ld_phase_path #(
    .TIMEOUT(TIMEOUT), .LOCK_WIN(LOCK_WIN),
    .UNLOCK_WIN(UNLOCK_WIN), .DECIM(DECIM)
  ) u_path (
    .clk(clk), .rstN(rstN), .powerDown(powerDown),
    .refPulse(refPulse), .fbPulse(fbPulse), .strobe(strobe)
  );

  ld_lock_ctrl #(.GOOD_RUN(GOOD_RUN)) u_ctrl (
    .clk(clk), .rstN(rstN), .powerDown(powerDown),
    .ldEnable(ldEnable), .strobe(strobe), .lockOut(lockOut)
  );
endmodule

// File: tb/pll_lock_filter_bench.sv
module pll_lock_filter_bench;
  localparam int SLOT = 40;
  localparam int PAIRS = 64;
  localparam int NVEC = 15;
  localparam int MISSING = 99;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerDown = 1'b0;
  logic ldEnable = 1'b1;
  logic refPulse = 1'b0;
  logic fbPulse = 1'b0;
  logic lockOut;
  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pll_lock_filter u_pll_lock_filter (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .ldEnable(ldEnable),
    .refPulse(refPulse), .fbPulse(fbPulse), .lockOut(lockOut)
  );

  typedef struct packed {
    logic signed [7:0] fill;  // offset of the 63 ignored pairs
    logic signed [7:0] last;  // offset of the compared pair
    logic              exp;   // expected lockOut after the group
    logic [3:0]        req;
  } vec_t;

  // Offset: fb edge minus ref edge in cycles; 99 = fb edge never comes.
  localparam vec_t VEC [NVEC] = '{
    '{8'sd5,  8'sd0,  1'b0, 4'd2},   // R2: wide fillers ignored
    '{8'sd5,  8'sd1,  1'b0, 4'd2},   // R2
    '{8'sd0,  8'sd0,  1'b0, 4'd3},   // R3: third good
    '{8'sd5,  8'sd0,  1'b1, 4'd3},   // R3: fourth good locks
    '{8'sd0,  8'sd2,  1'b1, 4'd6},   // R6: in-between keeps lock
    '{8'sd5, -8'sd1,  1'b1, 4'd1},   // R1: fb leads by one
    '{8'sd0,  8'sd3,  1'b0, 4'd5},   // R5: wide error unlocks
    '{8'sd0,  8'sd0,  1'b0, 4'd3},   // R3
    '{8'sd0,  8'sd0,  1'b0, 4'd3},   // R3
    '{8'sd0,  8'sd2,  1'b0, 4'd4},   // R4: run restarts
    '{8'sd0,  8'sd0,  1'b0, 4'd4},   // R4
    '{8'sd0,  8'sd0,  1'b0, 4'd4},   // R4
    '{8'sd0,  8'sd0,  1'b0, 4'd4},   // R4
    '{8'sd0,  8'sd0,  1'b1, 4'd4},   // R4: four after restart
    '{8'sd0,  8'sd99, 1'b0, 4'd7}    // R7: missing partner unlocks
  };

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: lockOut=%0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic pairSlot(input int off);
    int refAt = (off < 0) ? -off : 0;
    int fbAt = (off == MISSING) ? -1 : ((off < 0) ? 0 : off);
    for (int c = 0; c < SLOT; c++) begin
      @(posedge clk); #1;
      refPulse = (c == refAt);
      fbPulse  = (c == fbAt);
    end
  endtask

  task automatic group(input int fill, input int last);
    for (int p = 0; p < PAIRS - 1; p++) pairSlot(fill);
    pairSlot(last);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(lockOut, 1'b0, "R10 in reset");
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(lockOut, 1'b0, "R10 after reset");

    for (int i = 0; i < NVEC; i++) begin
      group(int'(VEC[i].fill), int'(VEC[i].last));
      checks++;
      if (lockOut !== VEC[i].exp) begin
        fails++;
        $display("FAIL R%0d row %0d: lockOut=%0b expected %0b",
                 VEC[i].req, i, lockOut, VEC[i].exp);
      end
    end

    // Relock, then test the enable gate (R8).
    for (int k = 0; k < 4; k++) group(0, 0);
    check(lockOut, 1'b1, "R3 relock");
    ldEnable = 1'b0;
    @(posedge clk); #1;
    check(lockOut, 1'b0, "R8 disabled");
    group(0, 0);
    check(lockOut, 1'b0, "R8 disabled during good group");
    ldEnable = 1'b1;
    @(posedge clk); #1;
    check(lockOut, 1'b1, "R8 state kept");

    // Power-down clears everything (R9).
    powerDown = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check(lockOut, 1'b0, "R9 powered down");
    powerDown = 1'b0;
    for (int k = 0; k < 3; k++) group(0, 0);
    check(lockOut, 1'b0, "R9 run cleared");
    group(0, 0);
    check(lockOut, 1'b1, "R9 lock after fresh run");

    rstN = 1'b0;
    @(posedge clk); #1;
    check(lockOut, 1'b0, "R10 reset while locked");
    rstN = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule